// File: doc/BRIEF.md
# I2C Bus Hang Watchdog with Clock-Pulse Recovery

This block watches the SCL and SDA lines of an I2C bus for periods with no signalling. These periods follow a transaction that ended badly. Both lines pass through a synchronizer, and any change on either one restarts a quiet-time counter. When the counter runs out, the block looks at SDA. If SDA is high, the bus is idle, so the block reports it as free with a single-cycle pulse. If SDA is low, some device is holding the data line. The block then pulls SCL low and releases it, up to nine times, so that the stuck device can shift out its bit and let go. After the pulses it reports a single-cycle completion.

The control word is four bits wide:
- A bit that turns the watchdog off.
- A bit that shortens the timeout from about one second to about fifty microseconds.
- A two-bit field that sets the output delay of the block's own SDA drive. The delay is 350 ns plus 50 ns per code step.

The timeouts are built from the system clock frequency and from microsecond parameters. A short test setting can therefore stand in for the real lengths.

Top module: `i2c_hang_guard`

## Requirements
- R1: After synchronous reset, `ctl_q` reads 0, and `scl_drive_low`, `sda_drive_low`, `bus_free` and `recovery_done` are all 0.
- R2: With fast=0, a quiet timeout ends `CLK_MHZ*SLOW_US` cycles after the last line change, to within the synchronizer latency of 0 to 6 cycles. If SDA is high at that point, `bus_free` pulses and SCL is not driven.
- R3: With fast=1, the quiet timeout lasts `CLK_MHZ*FAST_US` cycles, with the same latency allowance.
- R4: Any level change on SCL or SDA restarts the quiet-time count.
- R5: While off=1, no timeout is reported and SCL is released. Setting off during a recovery releases SCL within two cycles of the write, and `recovery_done` does not pulse.
- R6: If SDA is low when the timeout ends, the block starts recovery by driving SCL low, and `bus_free` does not pulse.
- R7: A recovery drives at most nine SCL pulses. Each pulse holds SCL low for `HALF_CYC` cycles and then releases it for `HALF_CYC` cycles. `recovery_done` pulses once at the end.
- R8: If SDA is seen high at the end of a released half-period, recovery stops after that pulse. The number of pulses is then the number needed for the holder to let go.
- R9: `bus_free` and `recovery_done` are one cycle wide and never high together. While the bus stays quiet with SDA high, `bus_free` repeats exactly every timeout length.
- R10: After a change of `sda_req`, `sda_drive_low` follows it D cycles later, where D = ceil((350 + 50*code) * CLK_MHZ / 1000). The code is `ctl_q[3:2]`.
- R11: When `ctl_we` is 1, `ctl_wdata` is loaded, and it is visible on `ctl_q` in the next cycle. Bit 0 is off, bit 1 is fast, and bits 3:2 are the delay code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Sensed SCL level |
| sda_in | input | 1 | Sensed SDA level |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 4 | Control write data |
| ctl_q | output | 4 | Current control word |
| sda_req | input | 1 | Request to pull SDA low, before the delay |
| scl_drive_low | output | 1 | Open-drain SCL pull-down enable |
| sda_drive_low | output | 1 | Delayed open-drain SDA pull-down enable |
| bus_free | output | 1 | One-cycle pulse when the bus is declared free |
| recovery_done | output | 1 | One-cycle pulse when recovery ends |

## Verification
The assertions check properties on every cycle:
- The two outcome pulses never coincide.
- A report of a free bus never comes while SCL is being driven.
- The pulse counter stays below nine.
- A line change always cancels a pending expiry.
- Turning the watchdog off releases SCL on the next cycle.

Only the bench scenarios can show the behaviour that depends on timing and on the bus:
- The timeout lengths in the normal and fast modes.
- The exact pulse count for each point at which the stuck device lets go.
- The per-code SDA delay.

// File: rtl/hang_guard_pkg.sv
`timescale 1ns/1ps
package hang_guard_pkg;

    // Control word layout: bit0 off, bit1 fast, bits 3:2 delay code
    typedef struct packed {
        logic [1:0] sda_dly;
        logic       fast;
        logic       off;
    } hg_ctl_t;

    typedef enum logic [1:0] {
        ST_WATCH = 2'd0,
        ST_PULL  = 2'd1,
        ST_LET   = 2'd2
    } hg_state_e;

    localparam int unsigned RECOVER_PULSES = 9;
    localparam int unsigned SDA_BASE_NS    = 350;
    localparam int unsigned SDA_STEP_NS    = 50;

    function automatic int unsigned sda_delay_cycles(input logic [1:0] code,
                                                     input int unsigned clk_mhz);
        int unsigned ns;
        ns = SDA_BASE_NS + SDA_STEP_NS * int'(code);
        return (ns * clk_mhz + 999) / 1000;
    endfunction

endpackage

// File: rtl/hg_line_sync.sv
`timescale 1ns/1ps
module hg_line_sync #(
    parameter int unsigned LINES  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] level,
    output logic [LINES-1:0] toggled
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
        logic [STAGES:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[STAGES-1:0], raw[g]};
        end
        assign level[g]   = chain[STAGES-1];
        assign toggled[g] = chain[STAGES-1] ^ chain[STAGES];
    end
endmodule

// File: rtl/hg_quiet_timer.sv
`timescale 1ns/1ps
module hg_quiet_timer #(
    parameter int unsigned SLOW_CYC = 50_000_000,
    parameter int unsigned FAST_CYC = 2_500
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic fast,
    input  logic activity,
    output logic expire
);
    localparam int unsigned W = $clog2(SLOW_CYC + 1);
    localparam logic [W-1:0] SLOW_LIM = W'(SLOW_CYC - 1);
    localparam logic [W-1:0] FAST_LIM = W'(FAST_CYC - 1);

    logic [W-1:0] cnt;
    logic [W-1:0] lim;

    assign lim    = fast ? FAST_LIM : SLOW_LIM;
    assign expire = run && !activity && (cnt >= lim);

    always_ff @(posedge clk) begin
        if (rst || !run || activity || expire) cnt <= '0;
        else                                   cnt <= cnt + 1'b1;
    end

    // R4
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        activity |=> !expire);
endmodule

// File: rtl/hg_recover.sv
`timescale 1ns/1ps
module hg_recover
    import hang_guard_pkg::*;
#(
    parameter int unsigned HALF_CYC = 250
) (
    input  logic clk,
    input  logic rst,
    input  logic off,
    input  logic expire,
    input  logic sda_hi,
    output logic watching,
    output logic scl_low,
    output logic bus_free,
    output logic rec_done
);
    localparam int unsigned HW = $clog2(HALF_CYC + 1);
    localparam logic [HW-1:0] HALF_LAST = HW'(HALF_CYC - 1);
    localparam logic [3:0]    LAST_PULSE = 4'(RECOVER_PULSES - 1);

    hg_state_e     state;
    logic [HW-1:0] hc;
    logic [3:0]    pc;

    assign watching = (state == ST_WATCH);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_WATCH;
            hc       <= '0;
            pc       <= '0;
            scl_low  <= 1'b0;
            bus_free <= 1'b0;
            rec_done <= 1'b0;
        end else begin
            bus_free <= 1'b0;
            rec_done <= 1'b0;
            if (off) begin
                state   <= ST_WATCH;
                scl_low <= 1'b0;
                hc      <= '0;
                pc      <= '0;
            end else begin
                case (state)
                    ST_WATCH: begin
                        if (expire) begin
                            if (sda_hi) begin
                                bus_free <= 1'b1;
                            end else begin
                                state   <= ST_PULL;
                                scl_low <= 1'b1;
                                hc      <= '0;
                                pc      <= '0;
                            end
                        end
                    end
                    ST_PULL: begin
                        if (hc == HALF_LAST) begin
                            hc      <= '0;
                            state   <= ST_LET;
                            scl_low <= 1'b0;
                        end else begin
                            hc <= hc + 1'b1;
                        end
                    end
                    ST_LET: begin
                        if (hc == HALF_LAST) begin
                            hc <= '0;
                            if (pc == LAST_PULSE || sda_hi) begin
                                rec_done <= 1'b1;
                                state    <= ST_WATCH;
                                pc       <= '0;
                            end else begin
                                pc      <= pc + 1'b1;
                                state   <= ST_PULL;
                                scl_low <= 1'b1;
                            end
                        end else begin
                            hc <= hc + 1'b1;
                        end
                    end
                    default: begin
                        state   <= ST_WATCH;
                        scl_low <= 1'b0;
                    end
                endcase
            end
        end
    end

    // R7
    pulse_cap_chk: assert property (@(posedge clk) disable iff (rst)
        pc < 4'(RECOVER_PULSES));
    // R9
    outcome_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_free && rec_done));
    // R6
    free_not_driving_chk: assert property (@(posedge clk) disable iff (rst)
        bus_free |-> !scl_low);
    // R5
    off_release_chk: assert property (@(posedge clk) disable iff (rst)
        off |=> !scl_low);
    // R9
    free_single_chk: assert property (@(posedge clk) disable iff (rst)
        bus_free |=> !bus_free);
endmodule

// File: rtl/hg_sda_delay.sv
`timescale 1ns/1ps
module hg_sda_delay
    import hang_guard_pkg::*;
#(
    parameter int unsigned CLK_MHZ = 50
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] code,
    input  logic       req,
    output logic       drive_low
);
    localparam int unsigned MAXD = sda_delay_cycles(2'd3, CLK_MHZ);

    logic [MAXD-1:0] line;
    int unsigned     tap;

    always_ff @(posedge clk) begin
        if (rst) line <= '0;
        else     line <= {line[MAXD-2:0], req};
    end

    always_comb begin
        tap       = sda_delay_cycles(code, CLK_MHZ);
        drive_low = 1'b0;
        for (int i = 0; i < int'(MAXD); i++) begin
            if (i + 1 == int'(tap)) drive_low = line[i];
        end
    end
endmodule

// File: rtl/i2c_hang_guard.sv
`timescale 1ns/1ps
module i2c_hang_guard
    import hang_guard_pkg::*;
#(
    parameter int unsigned CLK_MHZ  = 50,
    parameter int unsigned SLOW_US  = 1_000_000,
    parameter int unsigned FAST_US  = 50,
    parameter int unsigned HALF_CYC = 250
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic       ctl_we,
    input  logic [3:0] ctl_wdata,
    output logic [3:0] ctl_q,
    input  logic       sda_req,
    output logic       scl_drive_low,
    output logic       sda_drive_low,
    output logic       bus_free,
    output logic       recovery_done
);
    localparam int unsigned SLOW_CYC = CLK_MHZ * SLOW_US;
    localparam int unsigned FAST_CYC = CLK_MHZ * FAST_US;

    hg_ctl_t    cfg;
    logic [1:0] lvl, tog;
    logic       activity, expire, watching;

    always_ff @(posedge clk) begin
        if (rst)         cfg <= '0;
        else if (ctl_we) cfg <= hg_ctl_t'(ctl_wdata);
    end
    assign ctl_q = cfg;

    hg_line_sync #(.LINES(2), .STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .raw({sda_in, scl_in}),
        .level(lvl), .toggled(tog)
    );
    assign activity = |tog;

    hg_quiet_timer #(.SLOW_CYC(SLOW_CYC), .FAST_CYC(FAST_CYC)) u_timer (
        .clk(clk), .rst(rst), .run(watching && !cfg.off), .fast(cfg.fast),
        .activity(activity), .expire(expire)
    );

    hg_recover #(.HALF_CYC(HALF_CYC)) u_rec (
        .clk(clk), .rst(rst), .off(cfg.off), .expire(expire), .sda_hi(lvl[1]),
        .watching(watching), .scl_low(scl_drive_low),
        .bus_free(bus_free), .rec_done(recovery_done)
    );

    hg_sda_delay #(.CLK_MHZ(CLK_MHZ)) u_dly (
        .clk(clk), .rst(rst), .code(cfg.sda_dly), .req(sda_req),
        .drive_low(sda_drive_low)
    );

    // R11
    ctl_load_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_we |=> ctl_q == $past(ctl_wdata));
    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (ctl_q == 4'd0 && !scl_drive_low && !bus_free && !recovery_done));
endmodule

// File: tb/i2c_hang_guard_test.sv
`timescale 1ns/1ps
module i2c_hang_guard_test;
    localparam int CLK_MHZ = 50;
    localparam int SLOW    = CLK_MHZ * 40;
    localparam int FAST    = CLK_MHZ * 4;
    localparam int HALF    = 4;

    logic clk = 0, rst = 1;
    logic ctl_we = 0;
    logic [3:0] ctl_wdata = 0;
    logic [3:0] ctl_q;
    logic sda_req = 0;
    logic scl_drive_low, sda_drive_low, bus_free, recovery_done;
    logic tb_scl_low = 0, tb_sda_low = 0;
    logic slave_arm = 0;
    int   slave_k = 0, slave_base = 0, rises = 0;
    logic scl_bus, sda_bus;

    int vectors = 0, errors = 0;
    int free_cnt = 0, done_cnt = 0, pulse_cnt = 0, width_bad = 0;
    int hi_run = 0, gap = 0;

    always #10 clk = ~clk;

    assign scl_bus = ~(scl_drive_low | tb_scl_low);
    assign sda_bus = ~(tb_sda_low | (slave_arm && (rises - slave_base) < slave_k));

    i2c_hang_guard #(.CLK_MHZ(CLK_MHZ), .SLOW_US(40), .FAST_US(4), .HALF_CYC(HALF)) uut (
        .clk(clk), .rst(rst), .scl_in(scl_bus), .sda_in(sda_bus),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
        .sda_req(sda_req), .scl_drive_low(scl_drive_low),
        .sda_drive_low(sda_drive_low), .bus_free(bus_free),
        .recovery_done(recovery_done)
    );

    always @(posedge scl_bus) rises++;

    // Outcome and pulse-shape monitor
    always @(posedge clk) begin
        if (!rst) begin
            if (bus_free) free_cnt++;
            if (recovery_done) done_cnt++;
            if (scl_drive_low) begin
                if (hi_run == 0) begin
                    pulse_cnt++;
                    if (gap > 0 && gap <= 2 * HALF && gap != HALF) width_bad++;
                end
                hi_run++;
                gap = 0;
            end else begin
                if (hi_run != 0 && hi_run != HALF) width_bad++;
                hi_run = 0;
                gap++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_ctl(input logic [3:0] v);
        @(negedge clk); ctl_we = 1; ctl_wdata = v;
        @(negedge clk); ctl_we = 0;
    endtask

    task automatic mark_scl();
        @(negedge clk); tb_scl_low = 1;
        @(negedge clk); tb_scl_low = 0;
    endtask

    // Counts cycles until a timeout outcome shows on the ports
    task automatic wait_outcome(input int maxn, output int n, output bit was_free);
        n = 0;
        while (n < maxn && !(bus_free || scl_drive_low)) begin
            @(negedge clk); n++;
        end
        was_free = bus_free;
    endtask

    initial begin
        #(20 * 150_000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        int n, d, d0, p, f0;
        bit fr;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(ctl_q == 0 && !scl_drive_low && !sda_drive_low && !bus_free && !recovery_done,
            "R1", int'(ctl_q), 0);

        // R11 control load sweep
        for (int v = 0; v < 16; v++) begin
            write_ctl(4'(v));
            chk(ctl_q == 4'(v), "R11", int'(ctl_q), v);
        end
        write_ctl(4'd0);

        // R2 normal timeout, SDA high
        mark_scl();
        wait_outcome(SLOW + 50, n, fr);
        chk(n >= SLOW && n <= SLOW + 6, "R2", n, SLOW);
        chk(fr && !scl_drive_low, "R2", int'(fr), 1);

        // R3 fast timeout
        write_ctl(4'b0010);
        mark_scl();
        wait_outcome(FAST + 50, n, fr);
        chk(n >= FAST && n <= FAST + 6, "R3", n, FAST);
        chk(fr, "R3", int'(fr), 1);

        // R9 repetition period and width
        @(negedge clk);
        chk(!bus_free, "R9", int'(bus_free), 0);
        n = 1;
        while (!bus_free && n < FAST + 20) begin @(negedge clk); n++; end
        chk(n == FAST, "R9", n, FAST);

        // R4 activity restarts the count: edges every FAST/2 keep it quiet
        mark_scl();
        f0 = free_cnt;
        for (int i = 0; i < 6; i++) begin
            cyc(FAST / 2);
            if (i % 2 == 0) mark_scl();
            else begin
                @(negedge clk); tb_sda_low = 1;
                @(negedge clk); tb_sda_low = 0;
            end
        end
        chk(free_cnt == f0, "R4", free_cnt - f0, 0);

        // R5 disable: no outcome, no drive
        write_ctl(4'b0011);
        f0 = free_cnt; d0 = done_cnt; p = pulse_cnt;
        @(negedge clk); tb_sda_low = 1;
        cyc(3 * FAST);
        chk(free_cnt == f0 && pulse_cnt == p, "R5", pulse_cnt - p, 0);
        @(negedge clk); tb_sda_low = 0;
        write_ctl(4'b0010);

        // R6/R7/R8 recovery with holder releasing after k pulses
        for (int k = 1; k <= 12; k++) begin
            mark_scl();
            @(negedge clk);
            slave_base = rises; slave_k = k; slave_arm = 1;
            p = pulse_cnt; d0 = done_cnt; f0 = free_cnt;
            wait_outcome(FAST + 50, n, fr);
            chk(!fr && scl_drive_low && n >= FAST && n <= FAST + 6, "R6", n, FAST);
            n = 0;
            while (done_cnt == d0 && n < 40 * HALF) begin @(negedge clk); n++; end
            d = (k < 9) ? k : 9;
            chk(pulse_cnt - p == d, (k < 9) ? "R8" : "R7", pulse_cnt - p, d);
            chk(done_cnt - d0 == 1 && free_cnt == f0, "R7", done_cnt - d0, 1);
            @(negedge clk); slave_arm = 0;
        end
        chk(width_bad == 0, "R7", width_bad, 0);

        // R5 disable in the middle of a recovery
        mark_scl();
        @(negedge clk);
        slave_base = rises; slave_k = 99; slave_arm = 1;
        wait_outcome(FAST + 50, n, fr);
        cyc(2);
        d0 = done_cnt;
        @(negedge clk); ctl_we = 1; ctl_wdata = 4'b0011;
        @(negedge clk); ctl_we = 0;
        @(negedge clk);
        chk(!scl_drive_low, "R5", int'(scl_drive_low), 0);
        cyc(4 * HALF);
        chk(done_cnt == d0 && !scl_drive_low, "R5", done_cnt - d0, 0);
        @(negedge clk); slave_arm = 0;
        write_ctl(4'b0001);

        // R10 SDA output delay for every code, both directions
        for (int c = 0; c < 4; c++) begin
            write_ctl(4'((c << 2) | 1));
            d = ((350 + 50 * c) * CLK_MHZ + 999) / 1000;
            cyc(40);
            sda_req = 1;
            n = 0;
            while (!sda_drive_low && n < 60) begin @(negedge clk); n++; end
            chk(n == d, "R10", n, d);
            cyc(40);
            sda_req = 0;
            n = 0;
            while (sda_drive_low && n < 60) begin @(negedge clk); n++; end
            chk(n == d, "R10", n, d);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule